// File: doc/BRIEF.md
# Composite Sync Separator and Normalizer

This block sits between a raw, oversampled sync pin and a downstream line-rate phase comparator. The input may carry horizontal sync alone or TTL composite sync, and either level may be the active one. The block finds the active level itself and turns the input into a positive-going normalized signal. From that signal it produces exactly one fixed-width horizontal pulse per line, placed a constant number of clocks after the leading edge of each incoming sync pulse.

Equalizing pulses and other half-line pulses are removed by a blanking window that follows every accepted edge. Vertical sync is taken from composite sync by a leaky duty integrator. While vertical sync is active, missing line pulses are filled in from the measured line period, so the comparator never loses a beat. A valid flag shows that properly shaped horizontal sync has been seen recently.

Top module: `csync_sep`

## Requirements
- R1: While reset is high and right after it is released, hsync_out, vsync_out, sync_pol_low and sync_valid are all 0.
- R2: sync_pol_low reports 1 when the input is high for more than half of a window of WIN samples. It changes only at a window end, and only when two consecutive windows give the same verdict. It cannot change sooner than 1.5 windows after the input's polarity changes.
- R3: hsync_out is a high pulse of HS_W clocks. Its rising edge comes MIN_W+1 clocks after the first clock that samples the leading edge of the active sync level, for either input polarity.
- R4: An active pulse shorter than MIN_W samples produces no hsync_out pulse. A pulse of exactly MIN_W samples produces one.
- R5: After an accepted edge, further leading edges are ignored until 3/4 of the measured period has passed. Equalizing pulses at half-line spacing therefore add no hsync_out pulses, and rises of hsync_out are never closer than 3/4 of the period.
- R6: A saturating duty counter of DUTY_W bits adds 3 on each active sample and subtracts 1 on each inactive one. vsync_out is high while the counter exceeds VS_TH. A sustained 35% duty asserts vsync_out, and a sustained 20% duty never does.
- R7: While vsync_out is high and no edge arrives one measured period after the last pulse, a pulse is inserted at that point. Line-rate spacing is kept through a vertical interval that has no edges.
- R8: sync_valid rises only after a falling edge that ends an active pulse of at least MIN_W samples and less than 1/4 of the measured period. It falls when no such pulse has been seen for 4 measured periods.
- R9: The line period is the distance in clocks between consecutive accepted edges. After a silence of 4 periods, the next edge only restarts the measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Raw sync input, either polarity, H-only or composite |
| hsync_out | output | 1 | Normalized horizontal pulse, one per line |
| vsync_out | output | 1 | Extracted vertical sync, active high |
| sync_pol_low | output | 1 | 1 when the input's active level is low |
| sync_valid | output | 1 | Qualifying horizontal sync seen recently |

## Verification
Several properties are checked on every cycle. Polarity changes only at window boundaries. vsync_out rises only after an active sample and falls only after an inactive one. Every internal pulse decision is followed by a high hsync_out, consecutive hsync_out rises respect the blanking distance, and sync_valid rises only after a qualifying falling edge. Other behaviour can only be shown by the bench's scenarios. These cover the exact latency and width of hsync_out, the rejection of short glitches and equalizing pulses, the fill-in through an edge-free vertical block, the duty threshold on either side of 25%, the loss and recovery of sync_valid, and the two-window delay of the polarity decision.

// File: rtl/csync_pkg.sv
package csync_pkg;

    localparam int CS_CNT_W = 16;
    typedef logic [CS_CNT_W-1:0] cs_cnt_t;
    localparam cs_cnt_t CS_CNT_MAX = '1;

    // Source of a horizontal output pulse
    typedef enum logic [1:0] {
        HS_SRC_NONE,
        HS_SRC_EDGE,
        HS_SRC_FILL
    } hs_src_e;

    // Per-cycle events seen on the normalized sync signal
    typedef struct packed {
        logic    cand;   // active run just reached the minimum width
        logic    fall;   // active run just ended
        cs_cnt_t width;  // length of the run that just ended
    } pulse_ev_t;

    function automatic cs_cnt_t sat_inc(cs_cnt_t v);
        return (v == CS_CNT_MAX) ? v : v + 1'b1;
    endfunction

    // three quarters of a period
    function automatic cs_cnt_t blank_len(cs_cnt_t per);
        return (per >> 1) + (per >> 2);
    endfunction

    function automatic logic [CS_CNT_W+1:0] times4(cs_cnt_t v);
        return {v, 2'b00};
    endfunction

    // pulse width below a quarter of the period
    function automatic logic narrow_ok(cs_cnt_t w, cs_cnt_t per);
        return (per != '0) && (times4(w) < {2'b00, per});
    endfunction

endpackage

// File: rtl/csync_polarity.sv
module csync_polarity #(
    parameter int WIN = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    output logic pol_low
);
    localparam int WC_W = $clog2(WIN);
    localparam logic [WC_W-1:0] LAST = WC_W'(WIN - 1);
    localparam logic [WC_W:0]   HALF = (WC_W+1)'(WIN / 2);

    logic [WC_W-1:0] wcnt;
    logic [WC_W:0]   hcnt;
    logic [WC_W:0]   total;
    logic            vote;
    logic            prev_vote;
    logic            win_end;

    always_comb begin
        total   = hcnt + {{WC_W{1'b0}}, sample};
        vote    = total > HALF;
        win_end = (wcnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt      <= '0;
            hcnt      <= '0;
            prev_vote <= 1'b0;
            pol_low   <= 1'b0;
        end else if (win_end) begin
            wcnt      <= '0;
            hcnt      <= '0;
            prev_vote <= vote;
            if (vote == prev_vote) pol_low <= vote;
        end else begin
            wcnt <= wcnt + 1'b1;
            hcnt <= total;
        end
    end

    // R2: the decision moves only on a window boundary
    p_pol_change_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(pol_low) |-> $past(win_end));

endmodule

// File: rtl/csync_duty.sv
module csync_duty #(
    parameter int DUTY_W = 10,
    parameter int UP     = 3,
    parameter int DN     = 1,
    parameter int VTH    = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic vsync
);
    localparam logic [DUTY_W:0] UP_C  = (DUTY_W+1)'(UP);
    localparam logic [DUTY_W:0] DN_C  = (DUTY_W+1)'(DN);
    localparam logic [DUTY_W:0] TH_C  = (DUTY_W+1)'(VTH);
    localparam logic [DUTY_W:0] MAX_C = {1'b0, {DUTY_W{1'b1}}};

    logic [DUTY_W-1:0] acc;
    logic [DUTY_W:0]   ext;
    logic [DUTY_W:0]   up_sum;
    logic [DUTY_W:0]   nxt;

    always_comb begin
        ext    = {1'b0, acc};
        up_sum = ext + UP_C;
        if (active) nxt = (up_sum > MAX_C) ? MAX_C : up_sum;
        else        nxt = (ext < DN_C) ? '0 : ext - DN_C;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            vsync <= 1'b0;
        end else begin
            acc   <= nxt[DUTY_W-1:0];
            vsync <= nxt > TH_C;
        end
    end

    // R6: the vertical flag only climbs on active samples, only drops on idle ones
    p_vs_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync) |-> $past(active));
    p_vs_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync) |-> !$past(active));

endmodule

// File: rtl/csync_line.sv
module csync_line
    import csync_pkg::*;
#(
    parameter int MIN_W = 7,
    parameter int HS_W  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic norm,
    input  logic vsync,
    output logic hsync,
    output logic valid
);
    localparam cs_cnt_t MIN_C = cs_cnt_t'(MIN_W);
    localparam int HSC_W = $clog2(HS_W + 1);
    localparam logic [HSC_W-1:0] HS_LEN = HSC_W'(HS_W);

    logic             norm_d;
    cs_cnt_t          run;
    cs_cnt_t          since;
    cs_cnt_t          period;
    cs_cnt_t          idle;
    logic             have_prev;
    logic [HSC_W-1:0] hs_cnt;
    pulse_ev_t        ev;
    hs_src_e          src;
    logic             blanked;
    logic             qual;
    logic             lost;
    logic             idle_out;

    always_comb begin
        ev.cand  = norm && (run == MIN_C - 1'b1);
        ev.fall  = norm_d && !norm;
        ev.width = run;
        blanked  = (period != '0) && (since < blank_len(period));
        qual     = ev.fall && (ev.width >= MIN_C) && narrow_ok(ev.width, period);
        lost     = (period != '0) && ({2'b00, since} >= times4(period));
        idle_out = (period != '0) && ({2'b00, idle} >= times4(period));
        if (ev.cand && !blanked)
            src = HS_SRC_EDGE;
        else if (vsync && (period != '0) && (since >= period - 1'b1))
            src = HS_SRC_FILL;
        else
            src = HS_SRC_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            norm_d    <= 1'b0;
            run       <= '0;
            since     <= '0;
            period    <= '0;
            idle      <= '0;
            have_prev <= 1'b0;
            hs_cnt    <= '0;
            valid     <= 1'b0;
        end else begin
            norm_d <= norm;
            run    <= norm ? sat_inc(run) : '0;

            since <= (src != HS_SRC_NONE) ? '0 : sat_inc(since);

            if (src == HS_SRC_EDGE) begin
                have_prev <= 1'b1;
                if (have_prev && since != CS_CNT_MAX) period <= since + 1'b1;
            end else if (lost) begin
                have_prev <= 1'b0;
            end

            if (src != HS_SRC_NONE) hs_cnt <= HS_LEN;
            else if (hs_cnt != '0)  hs_cnt <= hs_cnt - 1'b1;

            idle <= qual ? '0 : sat_inc(idle);
            if (qual)          valid <= 1'b1;
            else if (idle_out) valid <= 1'b0;
        end
    end

    assign hsync = (hs_cnt != '0);

    // checker state: distance between output rises and period seen at the last rise
    logic    hs_q;
    cs_cnt_t gap_c;
    cs_cnt_t per_rec;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q    <= 1'b0;
            gap_c   <= '0;
            per_rec <= '0;
        end else begin
            hs_q <= hsync;
            if (hsync && !hs_q) begin
                gap_c   <= cs_cnt_t'(1);
                per_rec <= period;
            end else begin
                gap_c <= sat_inc(gap_c);
            end
        end
    end

    // R3: every pulse decision shows up on the output next cycle
    p_edge_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (src != HS_SRC_NONE) |=> hsync);

    // R5: output rises never come closer than the blanking distance
    p_min_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (hsync && !hs_q && per_rec != '0) |-> (gap_c >= blank_len(per_rec)));

    // R8: valid only turns on after a qualifying pulse ended
    p_valid_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(qual));

endmodule

// File: rtl/csync_sep.sv
module csync_sep
    import csync_pkg::*;
#(
    parameter int WIN     = 2048,
    parameter int MIN_W   = 7,
    parameter int HS_W    = 8,
    parameter int DUTY_W  = 10,
    parameter int DUTY_UP = 3,
    parameter int DUTY_DN = 1,
    parameter int VS_TH   = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic hsync_out,
    output logic vsync_out,
    output logic sync_pol_low,
    output logic sync_valid
);
    logic sync_q;
    logic norm;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b0;
        else     sync_q <= sync_in;
    end

    assign norm = sync_q ^ sync_pol_low;

    csync_polarity #(.WIN(WIN)) u_pol (
        .clk     (clk),
        .rst     (rst),
        .sample  (sync_q),
        .pol_low (sync_pol_low)
    );

    csync_duty #(
        .DUTY_W (DUTY_W),
        .UP     (DUTY_UP),
        .DN     (DUTY_DN),
        .VTH    (VS_TH)
    ) u_duty (
        .clk    (clk),
        .rst    (rst),
        .active (norm),
        .vsync  (vsync_out)
    );

    csync_line #(
        .MIN_W (MIN_W),
        .HS_W  (HS_W)
    ) u_line (
        .clk   (clk),
        .rst   (rst),
        .norm  (norm),
        .vsync (vsync_out),
        .hsync (hsync_out),
        .valid (sync_valid)
    );

endmodule

// File: tb/csync_sep_tb.sv
`timescale 1ns/1ps
module csync_sep_tb_top;
    localparam int CLK_P  = 10;
    localparam int PER    = 200;
    localparam int MIN_W  = 7;
    localparam int HS_W   = 8;
    localparam int WIN    = 2048;
    localparam int HSW    = 16;
    localparam int EQ_W   = 8;
    localparam int GL_AT  = 170;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_in = 1'b0;
    logic hsync_out, vsync_out, sync_pol_low, sync_valid;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    csync_sep #(.WIN(WIN), .MIN_W(MIN_W), .HS_W(HS_W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .sync_in      (sync_in),
        .hsync_out    (hsync_out),
        .vsync_out    (vsync_out),
        .sync_pol_low (sync_pol_low),
        .sync_valid   (sync_valid)
    );

    // monitor, sampled on the falling clock edge
    longint ncyc = 0;
    longint last_rise = -1;
    longint gap_min, gap_max;
    int     hs_count;
    int     hs_run = 0;
    int     hs_width = 0;
    bit     hs_prev = 1'b0;
    bit     vs_seen;
    time    t_lead = 0;
    time    lat = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (hsync_out && !hs_prev) begin
                hs_count++;
                if (last_rise >= 0) begin
                    if (ncyc - last_rise < gap_min) gap_min = ncyc - last_rise;
                    if (ncyc - last_rise > gap_max) gap_max = ncyc - last_rise;
                end
                last_rise = ncyc;
                lat = $time - t_lead;
            end
            if (hsync_out) hs_run++;
            else if (hs_prev) begin hs_width = hs_run; hs_run = 0; end
            if (vsync_out) vs_seen = 1'b1;
            hs_prev = hsync_out;
        end
        ncyc++;
    end

    task automatic seg_begin();
        hs_count = 0;
        gap_min  = 64'h7fff_ffff;
        gap_max  = 0;
        vs_seen  = 1'b0;
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one line of PER samples: main pulse, optional half-line pulse, optional glitch
    task automatic run_lines(input int n, input int width, input bit eq,
                             input int gw, input bit inv);
        for (int l = 0; l < n; l++) begin
            for (int i = 0; i < PER; i++) begin
                bit act;
                @(negedge clk);
                act = (i < width) ||
                      (eq && i >= PER/2 && i < PER/2 + EQ_W) ||
                      (gw > 0 && i >= GL_AT && i < GL_AT + gw);
                sync_in = act ^ inv;
                if (i == 0 && width > 0 && width < PER) t_lead = $time;
            end
        end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(!hsync_out && !vsync_out && !sync_pol_low && !sync_valid,
            "R1 outputs in reset", {hsync_out, vsync_out, sync_pol_low, sync_valid}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!hsync_out && !vsync_out && !sync_pol_low && !sync_valid,
            "R1 outputs after release", {hsync_out, vsync_out, sync_pol_low, sync_valid}, 0);
    endtask

    task automatic t_normal();
        run_lines(6, HSW, 0, 0, 0);
        seg_begin();
        run_lines(5, HSW, 0, 0, 0);
        chk(hs_count == 5, "R9 one pulse per line", hs_count, 5);
        chk(gap_min == PER && gap_max == PER, "R9 period spacing", gap_max, PER);
        chk(lat == (MIN_W + 1) * CLK_P, "R3 latency", lat, (MIN_W + 1) * CLK_P);
        chk(hs_width == HS_W, "R3 pulse width", hs_width, HS_W);
        chk(sync_valid == 1'b1, "R8 valid on clean sync", sync_valid, 1);
        chk(!vs_seen, "R6 no vsync on 8% duty", vs_seen, 0);
    endtask

    task automatic t_equalize();
        seg_begin();
        run_lines(6, HSW, 1, 0, 0);
        chk(hs_count == 6, "R5 equalizing pulses removed", hs_count, 6);
        chk(gap_min == PER && gap_max == PER, "R5 spacing kept", gap_min, PER);
    endtask

    task automatic t_glitch();
        seg_begin();
        run_lines(4, HSW, 0, MIN_W - 1, 0);
        chk(hs_count == 4, "R4 short glitch ignored", hs_count, 4);
        chk(gap_min == PER && gap_max == PER, "R4 spacing with glitch", gap_max, PER);
        seg_begin();
        run_lines(3, MIN_W, 0, 0, 0);
        chk(hs_count == 3, "R4 minimum width accepted", hs_count, 3);
        run_lines(3, HSW, 0, 0, 0);
    endtask

    task automatic t_duty();
        seg_begin();
        run_lines(12, 40, 0, 0, 0);
        chk(!vs_seen, "R6 20% duty no vsync", vs_seen, 0);
        chk(hs_count == 12, "R9 pulses at 20% duty", hs_count, 12);
        seg_begin();
        run_lines(12, 70, 0, 0, 0);
        chk(vs_seen, "R6 35% duty asserts vsync", vs_seen, 1);
        run_lines(12, HSW, 0, 0, 0);
        chk(!vsync_out, "R6 vsync released", vsync_out, 0);
    endtask

    task automatic t_fill();
        seg_begin();
        run_lines(1, PER, 0, 0, 0);
        run_lines(1, PER - 20, 0, 0, 0);
        run_lines(3, HSW, 0, 0, 0);
        chk(vs_seen, "R7 vsync during block", vs_seen, 1);
        chk(hs_count == 5, "R7 fill-in count", hs_count, 5);
        chk(gap_min == PER && gap_max == PER, "R7 fill-in spacing", gap_max, PER);
        run_lines(12, HSW, 0, 0, 0);
    endtask

    task automatic t_loss();
        seg_begin();
        run_lines(5, 0, 0, 0, 0);
        chk(hs_count == 0, "R7 no fill without vsync", hs_count, 0);
        chk(sync_valid == 1'b0, "R8 valid drops on silence", sync_valid, 0);
        run_lines(6, HSW, 0, 0, 0);
        chk(sync_valid == 1'b1, "R8 valid recovers", sync_valid, 1);
        seg_begin();
        run_lines(3, HSW, 0, 0, 0);
        chk(gap_min == PER && gap_max == PER, "R9 period relearned", gap_max, PER);
    endtask

    task automatic t_polarity();
        run_lines(12, HSW, 0, 0, 1);
        chk(sync_pol_low == 1'b0, "R2 held before two windows", sync_pol_low, 0);
        run_lines(28, HSW, 0, 0, 1);
        chk(sync_pol_low == 1'b1, "R2 negative sync found", sync_pol_low, 1);
        seg_begin();
        run_lines(5, HSW, 0, 0, 1);
        chk(hs_count == 5, "R3 pulses on negative sync", hs_count, 5);
        chk(gap_min == PER && gap_max == PER, "R9 spacing negative", gap_max, PER);
        chk(lat == (MIN_W + 1) * CLK_P, "R3 latency negative", lat, (MIN_W + 1) * CLK_P);
        chk(sync_valid == 1'b1, "R8 valid negative", sync_valid, 1);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_equalize();
        t_glitch();
        t_duty();
        t_fill();
        t_loss();
        t_polarity();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule